// File: doc/BRIEF.md
# Parallel Write-Only Display Bus Master

This block turns a stream of host bytes into write cycles on an 8-bit, strobe-style parallel bus with separate active-low chip select, write strobe and read strobe, the kind used to load commands and pixel data into a small display controller. Each host byte carries a flag that marks it as a command or as display data. The flag is driven onto a dedicated address line next to the data bus, low for a command and high for data.

Every bus interval is a parameter given in nanoseconds together with the system clock period. The block rounds each one up to whole clock cycles, so the bus minimums hold at any clock rate. The intervals are chip-select setup, address setup, data setup and hold, write-strobe low and high time, chip-select hold after the strobe and total cycle time. A transfer is a fixed sequence of four phases: setup, strobe low, hold and recovery. The host side is a valid/ready handshake that offers a new byte only after the recovery phase has ended. Read cycles are never issued, and the read strobe is held inactive.

Top module: `par_wr_master`

## Requirements
- R1: While `rst` is high at a clock edge, the block drives `bus_cs_n`, `bus_wr_n` and `bus_rd_n` high, `bus_data` and `bus_dc` to 0 and `host_ready` low. In the first cycle after release, `host_ready` is high.
- R2: A byte is taken at a clock edge where `host_valid` and `host_ready` are both high. `host_ready` is low from the next cycle until the transfer has fully ended. While `host_ready` is low, the host inputs have no effect on the bus.
- R3: `bus_dc` is driven to `host_is_data` (0 = command, 1 = display data). `bus_data` carries `host_byte`. Bytes appear on the bus, each with its own flag, in the order they were taken.
- R4: `bus_cs_n` and `bus_dc` change in the cycle after acceptance. `bus_wr_n` falls SU cycles later (default 1), which is at least the address setup time, and only while `bus_cs_n` is low.
- R5: `bus_wr_n` stays low for LO cycles (default 3). LO is at least the write-low minimum and the data setup minimum before the rising strobe edge.
- R6: After `bus_wr_n` rises, `bus_cs_n` stays low for HO cycles (default 1). `bus_data` and `bus_dc` stay unchanged until the next byte is taken.
- R7: `host_ready` returns after a recovery phase of RE cycles (default 10) with the bus idle. Falling strobe edges are at least the cycle-time minimum apart (default 16 cycles back to back), and the strobe high time meets its minimum.
- R8: `bus_rd_n` is high in every cycle.
- R9: Reset during a transfer ends it at that edge. The aborted byte is never completed, and the next accepted byte is written normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host offers a byte |
| host_ready | output | 1 | Block can take a byte this cycle |
| host_is_data | input | 1 | 1 = display data, 0 = command |
| host_byte | input | DW | Byte to write |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_dc | output | 1 | Command/data address line |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, held high |
| bus_data | output | DW | Parallel data bus |

## Verification
Each output is registered, so every bus change is due exactly one cycle after its cause. Chip select and the address line move one cycle after acceptance. The strobe falls SU cycles after that, rises LO cycles later, chip select rises HO cycles after the strobe and ready returns after RE further cycles. The bench keeps a count of cycles since acceptance, clocked on the same edges as the design, and compares every output half a cycle after each edge against the pin values that count implies. Independently of that model, it timestamps every strobe, chip-select, address and data edge and checks each edge-to-edge gap against its nanosecond minimum, rounded up to cycles.

// File: rtl/wrbus_pkg.sv
package wrbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LOW,
    PH_HOLD,
    PH_REST
  } wr_phase_e;

  // Whole clock cycles needed to cover a minimum time in ns.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wrbus_timer.sv
module wrbus_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/wrbus_seq.sv
module wrbus_seq
  import wrbus_pkg::*;
#(
  parameter int W  = 4,
  parameter int SU = 1,
  parameter int LO = 3,
  parameter int HO = 1,
  parameter int RE = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic         ready,
  input  logic         done,
  output wr_phase_e    phase_nxt,
  output logic         accept,
  output logic         load,
  output logic [W-1:0] load_val
);
  localparam logic [W-1:0] SU_LD = W'(SU - 1);
  localparam logic [W-1:0] LO_LD = W'(LO - 1);
  localparam logic [W-1:0] HO_LD = W'(HO - 1);
  localparam logic [W-1:0] RE_LD = W'(RE - 1);

  wr_phase_e phase_q;

  always_comb begin
    phase_nxt = phase_q;
    accept    = 1'b0;
    load      = 1'b0;
    load_val  = '0;
    case (phase_q)
      PH_IDLE: begin
        if (valid && ready) begin
          accept    = 1'b1;
          phase_nxt = PH_SETUP;
          load      = 1'b1;
          load_val  = SU_LD;
        end
      end
      PH_SETUP: begin
        if (done) begin
          phase_nxt = PH_LOW;
          load      = 1'b1;
          load_val  = LO_LD;
        end
      end
      PH_LOW: begin
        if (done) begin
          phase_nxt = PH_HOLD;
          load      = 1'b1;
          load_val  = HO_LD;
        end
      end
      PH_HOLD: begin
        if (done) begin
          phase_nxt = PH_REST;
          load      = 1'b1;
          load_val  = RE_LD;
        end
      end
      PH_REST: begin
        if (done) phase_nxt = PH_IDLE;
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_nxt;
  end
endmodule

// File: rtl/wrbus_drive.sv
module wrbus_drive
  import wrbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  wr_phase_e     phase_nxt,
  input  logic          accept,
  input  logic          is_data,
  input  logic [DW-1:0] byte_in,
  output logic          ready,
  output logic          cs_n,
  output logic          dc,
  output logic          wr_n,
  output logic          rd_n,
  output logic [DW-1:0] data
);
  logic sel_nxt;
  assign sel_nxt = (phase_nxt == PH_SETUP) || (phase_nxt == PH_LOW) ||
                   (phase_nxt == PH_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      cs_n  <= 1'b1;
      wr_n  <= 1'b1;
      rd_n  <= 1'b1;
      dc    <= 1'b0;
      data  <= '0;
    end else begin
      ready <= (phase_nxt == PH_IDLE);
      cs_n  <= !sel_nxt;
      wr_n  <= (phase_nxt != PH_LOW);
      rd_n  <= 1'b1;
      if (accept) begin
        dc   <= is_data;
        data <= byte_in;
      end
    end
  end
endmodule

// File: rtl/par_wr_master.sv
module par_wr_master
  import wrbus_pkg::*;
#(
  parameter int DW         = 8,
  parameter int CLK_NS     = 20,
  parameter int CS_SU_NS   = 0,
  parameter int ADDR_SU_NS = 10,
  parameter int DATA_SU_NS = 40,
  parameter int DATA_HO_NS = 7,
  parameter int WR_LOW_NS  = 60,
  parameter int WR_HIGH_NS = 60,
  parameter int CS_HO_NS   = 20,
  parameter int CYCLE_NS   = 300
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_valid,
  output logic          host_ready,
  input  logic          host_is_data,
  input  logic [DW-1:0] host_byte,
  output logic          bus_cs_n,
  output logic          bus_dc,
  output logic          bus_wr_n,
  output logic          bus_rd_n,
  output logic [DW-1:0] bus_data
);
  localparam int SU_CYC = imax(1, imax(ns_to_cyc(ADDR_SU_NS, CLK_NS),
                                       ns_to_cyc(CS_SU_NS, CLK_NS)));
  localparam int LO_CYC = imax(1, imax(ns_to_cyc(WR_LOW_NS, CLK_NS),
                                       ns_to_cyc(DATA_SU_NS, CLK_NS)));
  localparam int HO_CYC = imax(1, imax(ns_to_cyc(CS_HO_NS, CLK_NS),
                                       ns_to_cyc(DATA_HO_NS, CLK_NS)));
  localparam int RE_CYC = imax(1, imax(ns_to_cyc(WR_HIGH_NS, CLK_NS) - HO_CYC - SU_CYC,
                                       ns_to_cyc(CYCLE_NS, CLK_NS) - SU_CYC - LO_CYC - HO_CYC));
  localparam int MAX_CYC = imax(imax(SU_CYC, LO_CYC), imax(HO_CYC, RE_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  wr_phase_e         phase_nxt;
  logic              accept;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic              done;

  wrbus_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .done     (done)
  );

  wrbus_seq #(
    .W  (CNT_W),
    .SU (SU_CYC),
    .LO (LO_CYC),
    .HO (HO_CYC),
    .RE (RE_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .valid     (host_valid),
    .ready     (host_ready),
    .done      (done),
    .phase_nxt (phase_nxt),
    .accept    (accept),
    .load      (load),
    .load_val  (load_val)
  );

  wrbus_drive #(.DW(DW)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .phase_nxt (phase_nxt),
    .accept    (accept),
    .is_data   (host_is_data),
    .byte_in   (host_byte),
    .ready     (host_ready),
    .cs_n      (bus_cs_n),
    .dc        (bus_dc),
    .wr_n      (bus_wr_n),
    .rd_n      (bus_rd_n),
    .data      (bus_data)
  );
endmodule

// File: rtl/wrbus_chk.sv
module wrbus_chk #(
  parameter int DW = 8,
  parameter int LO = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          host_valid,
  input logic          host_ready,
  input logic          bus_cs_n,
  input logic          bus_dc,
  input logic          bus_wr_n,
  input logic [DW-1:0] bus_data
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || bus_wr_n) low_cnt <= '0;
    else                 low_cnt <= low_cnt + 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (bus_cs_n && bus_wr_n && !host_ready && bus_data == '0));

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_ready) |=> !host_ready);

  // R4
  strobe_in_select_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> !bus_cs_n);

  // R5
  strobe_low_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(bus_wr_n) && bus_wr_n && !$past(rst)) |-> (low_cnt >= 16'(LO)));

  // R6
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && !$past(bus_cs_n) && !$past(rst)) |-> ($stable(bus_data) && $stable(bus_dc)));

  // R7
  ready_idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (bus_cs_n && bus_wr_n));
endmodule

bind par_wr_master wrbus_chk #(.DW(DW), .LO(LO_CYC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_valid (host_valid),
  .host_ready (host_ready),
  .bus_cs_n   (bus_cs_n),
  .bus_dc     (bus_dc),
  .bus_wr_n   (bus_wr_n),
  .bus_data   (bus_data)
);

// File: tb/par_wr_master_test.sv
module par_wr_master_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       hv = 1'b0;
  logic       hd = 1'b0;
  logic [7:0] hb = 8'h00;
  logic       host_ready, bus_cs_n, bus_dc, bus_wr_n, bus_rd_n;
  logic [7:0] bus_data;

  par_wr_master uut (
    .clk(clk), .rst(rst), .host_valid(hv), .host_ready(host_ready),
    .host_is_data(hd), .host_byte(hb), .bus_cs_n(bus_cs_n), .bus_dc(bus_dc),
    .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_data(bus_data)
  );

  function automatic int cdiv(input int ns);
    return (ns + 19) / 20;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int B_SU  = mx(1, cdiv(10));
  localparam int B_LO  = mx(cdiv(60), cdiv(40));
  localparam int B_HO  = mx(1, mx(cdiv(20), cdiv(7)));
  localparam int B_RE  = mx(1, mx(cdiv(60) - B_HO - B_SU, cdiv(300) - B_SU - B_LO - B_HO));
  localparam int B_TOT = B_SU + B_LO + B_HO + B_RE;

  int errs = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: cycles since acceptance
  int         m_t = -1;
  bit         m_rdy = 1'b0;
  bit         m_rst = 1'b1;
  logic       m_dc = 1'b0;
  logic [7:0] m_data = 8'h00;
  logic [8:0] exp_q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_rst = 1'b1; m_t = -1; m_rdy = 1'b0; m_dc = 1'b0; m_data = 8'h00;
      exp_q.delete();
    end else begin
      m_rst = 1'b0;
      if (m_t < 0) begin
        if (m_rdy && hv) begin
          m_t = 0; m_dc = hd; m_data = hb; exp_q.push_back({hd, hb});
        end
      end else begin
        m_t++;
        if (m_t == B_TOT) m_t = -1;
      end
      m_rdy = (m_t < 0);
    end
  end

  int         cyc = 0;
  int         last_fall = -1, last_rise = -1000, dc_chg = 0, data_chg = 0;
  logic       prev_wr = 1'b1, prev_cs = 1'b1, prev_dc = 1'b0;
  logic [7:0] prev_data = 8'h00;

  always @(negedge clk) begin
    logic e_cs, e_wr;
    string tg;
    cyc++;
    e_cs = !(m_t >= 0 && m_t < B_SU + B_LO + B_HO);
    e_wr = !(m_t >= B_SU && m_t < B_SU + B_LO);
    tg = m_rst ? "R1 R9" : "R4 R5 R6";
    chk(bus_cs_n === e_cs, tg, "cs_n", int'(bus_cs_n), int'(e_cs));
    chk(bus_wr_n === e_wr, tg, "wr_n", int'(bus_wr_n), int'(e_wr));
    chk(host_ready === m_rdy, m_rst ? "R1" : "R2 R7", "ready", int'(host_ready), int'(m_rdy));
    chk(bus_dc === m_dc, m_rst ? "R1" : "R3", "dc", int'(bus_dc), int'(m_dc));
    chk(bus_data === m_data, m_rst ? "R1" : "R3 R6", "data", int'(bus_data), int'(m_data));
    chk(bus_rd_n === 1'b1, "R8", "rd_n", int'(bus_rd_n), 1);

    if (m_rst) begin
      last_fall = -1; last_rise = -1000; dc_chg = cyc; data_chg = cyc;
    end else begin
      if (bus_dc !== prev_dc) begin
        chk(cyc - last_rise >= 1, "R6", "dc hold after strobe", cyc - last_rise, 1);
        dc_chg = cyc;
      end
      if (bus_data !== prev_data) begin
        chk(cyc - last_rise >= cdiv(7), "R6", "data hold after strobe", cyc - last_rise, cdiv(7));
        data_chg = cyc;
      end
      if (prev_wr && !bus_wr_n) begin
        chk(cyc - dc_chg >= cdiv(10), "R4", "address setup", cyc - dc_chg, cdiv(10));
        chk(!bus_cs_n, "R4", "select at strobe fall", int'(bus_cs_n), 0);
        chk(cyc - last_rise >= cdiv(60), "R7", "strobe high time", cyc - last_rise, cdiv(60));
        if (last_fall >= 0)
          chk(cyc - last_fall >= cdiv(300), "R7", "cycle time", cyc - last_fall, cdiv(300));
        last_fall = cyc;
      end
      if (!prev_wr && bus_wr_n) begin
        chk(cyc - last_fall >= cdiv(60), "R5", "strobe low time", cyc - last_fall, cdiv(60));
        chk(cyc - data_chg >= cdiv(40), "R5", "data setup", cyc - data_chg, cdiv(40));
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected write", int'({bus_dc, bus_data}), 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({bus_dc, bus_data} === e, "R3", "written byte and flag",
              int'({bus_dc, bus_data}), int'(e));
        end
        last_rise = cyc;
      end
      if (!prev_cs && bus_cs_n)
        chk(cyc - last_rise >= cdiv(20), "R6", "select hold", cyc - last_rise, cdiv(20));
    end
    prev_wr = bus_wr_n; prev_cs = bus_cs_n; prev_dc = bus_dc; prev_data = bus_data;
  end

  task automatic send(input logic d, input logic [7:0] b);
    @(negedge clk);
    hv = 1'b1; hd = d; hb = b;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    hv = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: ready rises one cycle after release (checked every cycle)
    repeat (3) @(negedge clk);
    send(1'b0, 8'hAE);   // R3 command
    send(1'b1, 8'h55);   // R3 data
    repeat (20) @(negedge clk);
    // R7: back-to-back burst, mixed flags
    for (int i = 0; i < 6; i++) send(i[0], 8'h10 + 8'(i * 37));
    // R2: host inputs change while busy with valid low
    @(negedge clk); hv = 1'b1; hd = 1'b0; hb = 8'h81;
    @(negedge clk); hv = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); hd = ~hd; hb = 8'(i * 13 + 3);
    end
    send(1'b1, 8'hFF);
    send(1'b0, 8'h00);
    // R9: reset during strobe low
    @(negedge clk); hv = 1'b1; hd = 1'b1; hb = 8'hC3;
    while (!host_ready) @(negedge clk);
    @(negedge clk); hv = 1'b0;
    while (bus_wr_n) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    send(1'b0, 8'hA6);
    send(1'b1, 8'h3C);
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "bytes left unwritten", exp_q.size(), 0);
    chk(host_ready === 1'b1, "R7", "ready when drained", int'(host_ready), 1);
    finish_run();
  end
endmodule